// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a 32-bit register bus and fronts a byte-wide fuse store of 1024 entries. Software selects a fuse byte and bit through an address register. A command register starts two kinds of operation. A read copies the selected byte into a data register. A program operation ORs a single 1 into the selected bit, so a fuse can never return from 1 to 0. Programming starts only after a two-word unlock sequence, which keeps a stray write from burning a fuse.

A configuration register holds sticky lock bits. Each lock bit freezes a pair of protection fields, and software cannot clear it once it is set. A read-only strap word is formed by a bitwise two-of-three vote over three 32-bit copies held at the start of the fuse store. A separate preload port lets a test environment fill the fuse bytes before software starts accessing the block. Register reset leaves the fuse contents as they are.

Top module: `fuse_ctrl`

## Requirements
- R1: Word index `bus_addr[11:2]` selects the register: 0 status, 1 address, 2 data, 3 config, 4 strap, 5 command. Any access with `bus_addr[1:0]` nonzero, or to an index above 5, reads 0 and a write to it changes nothing. Read data is combinational while `bus_rd` is high and is 0 otherwise.
- R2: After reset, status reads 0x00000001, config reads 0x20000000, and address and data read 0. The fuse store keeps its contents through reset.
- R3: Writing 0x00000002 to the command register loads the fuse byte at address bits 9:0 into data bits 7:0 and sets status bits 1 and 0.
- R4: Writing 0xBF79E5D0 to the command register, when the previous command write was 0x00000001, sets the fuse bit at byte address bits 9:0 and bit position bits 12:10. It sets status bits 1 and 0. Bits already at 1 stay at 1.
- R5: A command write of any value other than 0x00000001 disarms the sequence, so the magic word without a directly preceding arm word programs nothing. The command register reads as 0.
- R6: Status bit 2 is read/write. Writing 1 to status bit 1 clears it. Writes never set bits 1 or 0.
- R7: The data register ignores writes. The only exception is the value 0x00000001, which clears it.
- R8: Config bits 31 and 23:16 are set by writing 1 and cannot be cleared. While bit 16+k is set, bits 8+k and k keep their value. All other config bits are read/write.
- R9: The strap register reads the bitwise majority of three little-endian words held in fuse bytes 0-3, 4-7 and 8-11. Writes to it are ignored.
- R10: A preload write replaces the whole fuse byte at `pre_addr` with `pre_data`.
- R11: The address register stores write bits 12:0, and its bits 31:13 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pre_we | input | 1 | Fuse preload write enable |
| pre_addr | input | 10 | Fuse preload byte address |
| pre_data | input | 8 | Fuse preload byte value |

## Verification
A lost or spurious arm state shows up only in the fuse contents. The bench therefore follows every program attempt with a read command and a data read two cycles later, so a wrongly accepted or refused unlock appears at once. Lock and sticky errors show on the first config read after a write that tries to undo them. A wrong strap vote, or a wrong byte order in it, shows on the first strap read after the three copies are preloaded to disagree.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned BYTE_AW = 10;
  localparam int unsigned BIT_AW  = 3;
  localparam int unsigned FADR_W  = BYTE_AW + BIT_AW;

  localparam logic [BUS_W-1:0] CMD_LOAD  = 32'h0000_0002;
  localparam logic [BUS_W-1:0] CMD_ARM   = 32'h0000_0001;
  localparam logic [BUS_W-1:0] CMD_BURN  = 32'hBF79_E5D0;
  localparam logic [BUS_W-1:0] DATA_WIPE = 32'h0000_0001;
  localparam logic [BUS_W-1:0] CFG_RST   = 32'h2000_0000;
  localparam logic [BUS_W-1:0] CFG_STICK = 32'h80FF_0000;

  typedef enum logic [9:0] {
    IX_STAT = 10'd0,
    IX_ADDR = 10'd1,
    IX_DATA = 10'd2,
    IX_CFG  = 10'd3,
    IX_STRP = 10'd4,
    IX_CMD  = 10'd5
  } reg_ix_e;

  // Next config: sticky bits stay set, locked fields keep their old value.
  function automatic logic [BUS_W-1:0] cfg_next(input logic [BUS_W-1:0] cur,
                                                input logic [BUS_W-1:0] wr);
    logic [BUS_W-1:0] lk;
    lk = {16'h0, cur[23:16], cur[23:16]};
    return (cur & (CFG_STICK | lk)) | (wr & ~lk);
  endfunction

  function automatic logic [BUS_W-1:0] vote3(input logic [BUS_W-1:0] a,
                                             input logic [BUS_W-1:0] b,
                                             input logic [BUS_W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_pkg::*;
#(
  parameter int unsigned AW     = BYTE_AW,
  parameter int unsigned BW     = BIT_AW,
  parameter int unsigned COPIES = 3
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [AW-1:0]     pre_addr,
  input  logic [7:0]        pre_data,
  input  logic              prog_en,
  input  logic [AW-1:0]     prog_addr,
  input  logic [BW-1:0]     prog_bit,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_byte,
  output logic [BUS_W-1:0]  strap_word
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned WBYTE = BUS_W / 8;

  logic [7:0] mem [DEPTH];
  logic [BUS_W-1:0] copy_w [COPIES];

  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (prog_en) mem[prog_addr] <= mem[prog_addr] | (8'h01 << prog_bit);
  end

  assign rd_byte = mem[rd_addr];

  for (genvar w = 0; w < COPIES; w++) begin : g_copy
    for (genvar b = 0; b < WBYTE; b++) begin : g_byte
      assign copy_w[w][8*b +: 8] = mem[w*WBYTE + b];
    end
  end

  assign strap_word = vote3(copy_w[0], copy_w[1], copy_w[2]);

  AST_FUSE_SET: assert property (@(posedge clk)
    (prog_en && !pre_we) |=> mem[$past(prog_addr)][$past(prog_bit)]) // R4
    else $error("programmed fuse bit not set");
endmodule

// File: rtl/fuse_cmd_seq.sv
module fuse_cmd_seq
  import fuse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [BUS_W-1:0] cmd_val,
  output logic             load_fire,
  output logic             burn_fire
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (cmd_wr) armed_q <= (cmd_val == CMD_ARM);
  end

  assign load_fire = cmd_wr && (cmd_val == CMD_LOAD);
  assign burn_fire = cmd_wr && (cmd_val == CMD_BURN) && armed_q;

  AST_BURN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    burn_fire |-> $past(cmd_wr && cmd_val == CMD_ARM) || $past(armed_q && !cmd_wr)) // R5
    else $error("burn without arm");
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [11:0]       bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pre_we,
  input  logic [BYTE_AW-1:0] pre_addr,
  input  logic [7:0]        pre_data
);
  logic              aligned;
  logic [9:0]        ix;
  logic              wr_stat, wr_addr, wr_data, wr_cfg, wr_cmd;
  logic              load_fire, burn_fire, data_wipe;
  logic              st_ie, st_done, st_rdy;
  logic [FADR_W-1:0] fadr_q;
  logic [7:0]        data_q;
  logic [BUS_W-1:0]  cfg_q;
  logic [7:0]        arr_byte;
  logic [BUS_W-1:0]  strap_w;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign ix        = bus_addr[11:2];
  assign wr_stat   = bus_wr && aligned && ix == IX_STAT;
  assign wr_addr   = bus_wr && aligned && ix == IX_ADDR;
  assign wr_data   = bus_wr && aligned && ix == IX_DATA;
  assign wr_cfg    = bus_wr && aligned && ix == IX_CFG;
  assign wr_cmd    = bus_wr && aligned && ix == IX_CMD;
  assign data_wipe = wr_data && bus_wdata == DATA_WIPE;

  fuse_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .cmd_val(bus_wdata),
    .load_fire(load_fire), .burn_fire(burn_fire)
  );

  fuse_store #(.AW(BYTE_AW), .BW(BIT_AW), .COPIES(3)) u_store (
    .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .prog_en(burn_fire), .prog_addr(fadr_q[BYTE_AW-1:0]),
    .prog_bit(fadr_q[FADR_W-1:BYTE_AW]), .rd_addr(fadr_q[BYTE_AW-1:0]),
    .rd_byte(arr_byte), .strap_word(strap_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ie   <= 1'b0;
      st_done <= 1'b0;
      st_rdy  <= 1'b1;
      fadr_q  <= '0;
      data_q  <= '0;
      cfg_q   <= CFG_RST;
    end else begin
      if (wr_stat) begin
        st_ie <= bus_wdata[2];
        if (bus_wdata[1]) st_done <= 1'b0;
      end
      if (load_fire || burn_fire) begin
        st_done <= 1'b1;
        st_rdy  <= 1'b1;
      end
      if (wr_addr) fadr_q <= bus_wdata[FADR_W-1:0];
      if (load_fire)      data_q <= arr_byte;
      else if (data_wipe) data_q <= '0;
      if (wr_cfg) cfg_q <= cfg_next(cfg_q, bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      case (ix)
        IX_STAT: bus_rdata = {29'h0, st_ie, st_done, st_rdy};
        IX_ADDR: bus_rdata = {{(BUS_W-FADR_W){1'b0}}, fadr_q};
        IX_DATA: bus_rdata = {24'h0, data_q};
        IX_CFG:  bus_rdata = cfg_q;
        IX_STRP: bus_rdata = strap_w;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_OP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire || burn_fire) |=> (st_done && st_rdy)) // R3
    else $error("operation did not flag done");
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q[23:16] & $past(cfg_q[23:16])) == $past(cfg_q[23:16])) && (!$past(cfg_q[31]) || cfg_q[31])) // R8
    else $error("sticky config bit cleared");
  AST_LOCKED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (((cfg_q[7:0] ^ $past(cfg_q[7:0])) | (cfg_q[15:8] ^ $past(cfg_q[15:8]))) & $past(cfg_q[23:16])) == 8'h00) // R8
    else $error("locked config field changed");
  AST_DATA_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(load_fire) || $past(data_wipe)) // R7
    else $error("data register changed without cause");
  AST_DONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(load_fire || burn_fire)) // R6
    else $error("done bit set by a write");
endmodule

// File: tb/tb_fuse_ctrl.sv
module tb_fuse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [7:0]  pre_data = '0;

  int checks = 0, failures = 0;
  bit ended = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  shadow [16];

  always #2 clk = ~clk;

  fuse_ctrl dut (.*);

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic preload(input logic [9:0] a, input logic [7:0] d);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(posedge clk); #1;
    pre_we = 1'b0;
  endtask

  task automatic fetch(input logic [9:0] a, input logic [31:0] e, input string t);
    wr(12'h004, {22'h0, a});
    wr(12'h014, 32'h2);
    rd(12'h008, e, t);
  endtask

  function automatic logic [31:0] maj(input logic [31:0] a, b, c);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (a[i] + b[i] + c[i]) >= 2;
    return r;
  endfunction

  initial begin
    logic [31:0] w0, w1, w2;
    w0 = 32'hF0F0_F0F0; w1 = 32'hFF00_FF00; w2 = 32'h0000_FFFF;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R2 reset values
    rd(12'h000, 32'h1, "R2 status reset");
    rd(12'h00C, 32'h2000_0000, "R2 config reset");
    rd(12'h004, 32'h0, "R2 address reset");
    rd(12'h008, 32'h0, "R2 data reset");
    // R10 preload, R9 strap
    for (int i = 0; i < 4; i++) begin
      shadow[i] = w0[8*i +: 8]; shadow[4+i] = w1[8*i +: 8]; shadow[8+i] = w2[8*i +: 8];
    end
    shadow[12] = 8'h10; shadow[13] = 8'hA5; shadow[14] = 8'h00; shadow[15] = 8'h7E;
    for (int i = 0; i < 16; i++) preload(10'(i), shadow[i]);
    preload(10'd13, 8'h3C); shadow[13] = 8'h3C;
    rd(12'h010, maj(w0, w1, w2), "R9 strap vote");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, maj(w0, w1, w2), "R9 strap write ignored");
    // R3 load
    fetch(10'd13, {24'h0, shadow[13]}, "R10 R3 load preloaded byte");
    rd(12'h000, 32'h3, "R3 status done+ready");
    // R6 status
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h3, "R6 zero write keeps done");
    wr(12'h000, 32'h2);
    rd(12'h000, 32'h1, "R6 W1C done");
    wr(12'h000, 32'h4);
    rd(12'h000, 32'h5, "R6 ie read/write");
    wr(12'h000, 32'h0);
    // R7 data
    wr(12'h008, 32'h55);
    rd(12'h008, {24'h0, shadow[13]}, "R7 data write ignored");
    wr(12'h008, 32'h1);
    rd(12'h008, 32'h0, "R7 data wipe");
    // R11 address
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0000_1FFF, "R11 address width");
    // R4 program bit 3 of byte 12
    wr(12'h004, 32'h0000_0C0C);
    wr(12'h014, 32'h1);
    wr(12'h014, 32'hBF79_E5D0);
    rd(12'h000, 32'h3, "R4 status after program");
    shadow[12] = shadow[12] | 8'h08;
    fetch(10'd12, {24'h0, shadow[12]}, "R4 program sets bit");
    // R4 already-set bit stays
    wr(12'h004, 32'h0000_100C);
    wr(12'h014, 32'h1);
    wr(12'h014, 32'hBF79_E5D0);
    fetch(10'd12, {24'h0, shadow[12]}, "R4 set bit stays set");
    // R5 broken sequence: bit 0 of byte 14
    wr(12'h004, 32'h0000_000E);
    wr(12'h014, 32'h1);
    wr(12'h014, 32'h5);
    wr(12'h014, 32'hBF79_E5D0);
    fetch(10'd14, 32'h0, "R5 interrupted arm");
    wr(12'h004, 32'h0000_000E);
    wr(12'h014, 32'hBF79_E5D0);
    fetch(10'd14, 32'h0, "R5 burn without arm");
    rd(12'h014, 32'h0, "R5 command reads zero");
    // R8 config locks
    wr(12'h00C, 32'h0001_0303);
    rd(12'h00C, 32'h0001_0303, "R8 config write");
    wr(12'h00C, 32'h0);
    rd(12'h00C, 32'h0001_0101, "R8 lock holds fields");
    wr(12'h00C, 32'h8000_0000);
    wr(12'h00C, 32'h0);
    rd(12'h00C, 32'h8001_0101, "R8 disable bit sticky");
    // R1 map edges
    rd(12'h018, 32'h0, "R1 undefined offset");
    rd(12'h00D, 32'h0, "R1 unaligned read");
    wr(12'h005, 32'h0000_0055);
    rd(12'h004, 32'h0000_000E, "R1 unaligned write ignored");
    // R2 fuse contents survive reset
    rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1; @(posedge clk); #1;
    rd(12'h00C, 32'h2000_0000, "R2 config after second reset");
    fetch(10'd12, {24'h0, shadow[12]}, "R2 fuses kept over reset");
    repeat (2) @(posedge clk);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule